// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the source and destination addresses for a single DMA channel. Each side keeps two registers: a programmed start address and a working address. While the channel is running, every transferred byte moves each working address according to its side's direction setting: it holds, counts up or counts down. A per-side reload policy picks a transfer boundary (burst, block or whole transaction) at which the working address returns to its start value.

Software sets up the channel through a small byte-wide register port. That port carries a trigger-select register, a packed mode register and the two start addresses. The channel starts on a trigger request, but only if the trigger select is non-zero. Once started, the channel locks its mode and address registers until the end of the transaction. The surrounding engine supplies the per-byte step and the burst, block and transaction end strobes. It consumes the two working addresses.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `busy` is 0, both addresses read 0, and the trigger-select and mode registers read 0.
- R2: The register map is as follows. Offset 0 is the 8-bit trigger select. Offset 1 is the mode register: [1:0] source direction, [3:2] source reload, [5:4] destination direction, [7:6] destination reload. Offsets 2/3 hold the source address low/high byte and offsets 4/5 the destination address low/high byte. A write to an address byte while idle sets both the start value and the working value. A read of an address offset returns the working address.
- R3: A `trig_req` pulse while idle with a non-zero trigger select sets `busy` on the next cycle. With a zero trigger select, `busy` stays 0.
- R4: On `step` while busy, direction code 00 holds the address, 01 adds 1, 10 subtracts 1, and 11 holds. Both up and down counts wrap modulo 2^16.
- R5: Reload codes are 00 never, 01 block end, 10 burst end and 11 transaction end. A block end also counts as a burst end. A transaction end counts as all three.
- R6: When a reload and a step fall in the same cycle, the working address takes the start value.
- R7: While busy, writes to the mode register and to the address bytes are ignored. A write to the trigger select takes effect at any time.
- R8: `xact_end` while busy clears `busy` on the next cycle.
- R9: While idle, `step` and the end strobes leave both addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| trig_req | input | 1 | Trigger request from the selected source |
| step | input | 1 | One byte transferred this cycle |
| burst_end | input | 1 | Current burst completes this cycle |
| blk_end | input | 1 | Current block completes this cycle |
| xact_end | input | 1 | Transaction completes this cycle |
| busy | output | 1 | Channel running |
| src_addr | output | 16 | Working source address |
| dst_addr | output | 16 | Working destination address |

## Verification
The hardest situation to reach from the ports is a reload and a step landing in the same cycle while the working address already differs from its start value. The stimulus first steps both sides away from their start values, and through zero on the down-counting side. It then drives a burst end together with a step, so that one side must reload while the other must keep counting. A second transaction reprograms the mode to reach the reserved direction code and the never-reload policy. A third pass writes the locked registers while busy and reads them back.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10,
    DIR_RSVD = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    RL_NEVER = 2'b00,
    RL_BLOCK = 2'b01,
    RL_BURST = 2'b10,
    RL_XACT  = 2'b11
  } reload_e;

  // bit 0 of the packed struct is the last field
  typedef struct packed {
    reload_e dst_rl;
    dir_e    dst_dir;
    reload_e src_rl;
    dir_e    src_dir;
  } mode_t;

  localparam int unsigned OFS_TRIG = 0;
  localparam int unsigned OFS_MODE = 1;
  localparam int unsigned OFS_SRC  = 2;

  function automatic logic reload_fires(reload_e rl, logic burst_end,
                                        logic blk_end, logic xact_end);
    logic hit;
    case (rl)
      RL_NEVER: hit = 1'b0;
      RL_BLOCK: hit = blk_end | xact_end;
      RL_BURST: hit = burst_end | blk_end | xact_end;
      default:  hit = xact_end;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/dag_cfg.sv
module dag_cfg
  import dag_pkg::*;
#(
  parameter int DW  = 8,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           trig_req,
  input  logic           xact_end,
  output logic [DW-1:0]  trig_sel_q,
  output mode_t          mode_q,
  output logic           busy_q
);

  localparam int MW = $bits(mode_t);

  logic          trig_en, mode_en;
  logic [DW-1:0] trig_d;
  mode_t         mode_d;
  logic          busy_d;

  always_comb begin
    trig_en = reg_wr && (reg_addr == RAW'(OFS_TRIG));
    mode_en = reg_wr && !busy_q && (reg_addr == RAW'(OFS_MODE));
    trig_d  = reg_wdata;
    mode_d  = mode_t'(reg_wdata[MW-1:0]);
    if (busy_q) busy_d = !xact_end;
    else        busy_d = trig_req && (|trig_sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_sel_q <= '0;
      mode_q     <= '0;
      busy_q     <= 1'b0;
    end else begin
      if (trig_en) trig_sel_q <= trig_d;
      if (mode_en) mode_q     <= mode_d;
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/dag_addr_side.sv
module dag_addr_side
  import dag_pkg::*;
#(
  parameter  int AW   = 16,
  parameter  int DW   = 8,
  parameter  int RAW  = 3,
  parameter  int BASE = 2,
  localparam int NB   = AW / DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           busy,
  input  logic           step,
  input  logic           burst_end,
  input  logic           blk_end,
  input  logic           xact_end,
  input  dir_e           dir,
  input  reload_e        rl,
  output logic [AW-1:0]  cur_q,
  output logic [AW-1:0]  init_q,
  output logic [DW-1:0]  rd_byte,
  output logic           rd_hit
);

  logic [NB-1:0] sel;
  logic [AW-1:0] cur_d, init_d;
  logic          reload, init_en, cur_en;

  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign sel[b] = (reg_addr == RAW'(BASE + b));
  end

  always_comb begin
    init_d  = init_q;
    cur_d   = cur_q;
    rd_byte = '0;
    reload  = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (sel[b]) rd_byte = cur_q[b*DW +: DW];
    end
    if (wr_en) begin
      for (int b = 0; b < NB; b++) begin
        if (sel[b]) begin
          init_d[b*DW +: DW] = reg_wdata;
          cur_d[b*DW +: DW]  = reg_wdata;
        end
      end
    end
    if (busy) begin
      reload = reload_fires(rl, burst_end, blk_end, xact_end);
      if (reload) begin
        cur_d = init_q;
      end else if (step) begin
        case (dir)
          DIR_UP:   cur_d = cur_q + AW'(1);
          DIR_DOWN: cur_d = cur_q - AW'(1);
          default:  cur_d = cur_q;
        endcase
      end
    end
  end

  assign rd_hit  = |sel;
  assign init_en = wr_en && rd_hit;
  assign cur_en  = init_en || (busy && (reload || step));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      cur_q  <= '0;
    end else begin
      if (init_en) init_q <= init_d;
      if (cur_en)  cur_q  <= cur_d;
    end
  end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
#(
  parameter  int AW  = 16,
  parameter  int DW  = 8,
  localparam int NB  = AW / DW,
  localparam int RAW = $clog2(OFS_SRC + 2 * NB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           trig_req,
  input  logic           step,
  input  logic           burst_end,
  input  logic           blk_end,
  input  logic           xact_end,
  output logic           busy,
  output logic [AW-1:0]  src_addr,
  output logic [AW-1:0]  dst_addr
);

  localparam int NSIDE = 2;

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic [DW-1:0] trig_sel_q;
  mode_t         mode_q;
  logic          busy_q;
  logic          addr_wr;

  dir_e          side_dir  [NSIDE];
  reload_e       side_rl   [NSIDE];
  logic [AW-1:0] side_cur  [NSIDE];
  logic [AW-1:0] side_init [NSIDE];
  logic [DW-1:0] side_rd   [NSIDE];
  logic [NSIDE-1:0] side_hit;
  logic [AW-1:0] src_init, dst_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dag_cfg #(.DW(DW), .RAW(RAW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .trig_req   (trig_req),
    .xact_end   (xact_end),
    .trig_sel_q (trig_sel_q),
    .mode_q     (mode_q),
    .busy_q     (busy_q)
  );

  assign addr_wr     = reg_wr && !busy_q;
  assign side_dir[0] = mode_q.src_dir;
  assign side_dir[1] = mode_q.dst_dir;
  assign side_rl[0]  = mode_q.src_rl;
  assign side_rl[1]  = mode_q.dst_rl;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dag_addr_side #(
      .AW(AW), .DW(DW), .RAW(RAW), .BASE(OFS_SRC + s * NB)
    ) u_side (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .wr_en     (addr_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .busy      (busy_q),
      .step      (step),
      .burst_end (burst_end),
      .blk_end   (blk_end),
      .xact_end  (xact_end),
      .dir       (side_dir[s]),
      .rl        (side_rl[s]),
      .cur_q     (side_cur[s]),
      .init_q    (side_init[s]),
      .rd_byte   (side_rd[s]),
      .rd_hit    (side_hit[s])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RAW'(OFS_TRIG)) begin
      reg_rdata = trig_sel_q;
    end else if (reg_addr == RAW'(OFS_MODE)) begin
      reg_rdata = DW'(mode_q);
    end else begin
      for (int s = 0; s < NSIDE; s++) begin
        if (side_hit[s]) reg_rdata = side_rd[s];
      end
    end
  end

  assign busy     = busy_q;
  assign src_addr = side_cur[0];
  assign dst_addr = side_cur[1];
  assign src_init = side_init[0];
  assign dst_init = side_init[1];

endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          reg_wr,
  input logic [DW-1:0] trig_sel,
  input logic [7:0]    mode,
  input logic          step,
  input logic          burst_end,
  input logic          blk_end,
  input logic          xact_end,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [AW-1:0] src_init,
  input logic [AW-1:0] dst_init
);

  logic src_hit, dst_hit;

  function automatic logic boundary(logic [1:0] code, logic bu, logic bl, logic xa);
    return (code == 2'b01 && (bl || xa)) ||
           (code == 2'b10 && (bu || bl || xa)) ||
           (code == 2'b11 && xa);
  endfunction

  always_comb begin
    src_hit = busy && boundary(mode[3:2], burst_end, blk_end, xact_end);
    dst_hit = busy && boundary(mode[7:6], burst_end, blk_end, xact_end);
  end

  // R3
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig_sel == '0) |=> !busy);

  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xact_end) |=> !busy);

  // R6
  src_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_hit |=> (src_addr == $past(src_init)));

  // R6
  dst_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_hit |=> (dst_addr == $past(dst_init)));

  // R4
  src_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step && !src_hit && mode[1:0] == 2'b01) |=>
      (src_addr == $past(src_addr) + AW'(1)));

  // R4
  dst_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step && !dst_hit && mode[5:4] == 2'b10) |=>
      (dst_addr == $past(dst_addr) - AW'(1)));

  // R7
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reg_wr) |=> ($stable(src_addr) && $stable(dst_addr)));

endmodule

bind dma_addr_gen dag_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .busy      (busy_q),
  .reg_wr    (reg_wr),
  .trig_sel  (trig_sel_q),
  .mode      (mode_q),
  .step      (step),
  .burst_end (burst_end),
  .blk_end   (blk_end),
  .xact_end  (xact_end),
  .src_addr  (src_addr),
  .dst_addr  (dst_addr),
  .src_init  (src_init),
  .dst_init  (dst_init)
);

// File: tb/dma_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        trig_req = 1'b0;
  logic        step = 1'b0, burst_end = 1'b0, blk_end = 1'b0, xact_end = 1'b0;
  logic        busy;
  logic [15:0] src_addr, dst_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  dma_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_req(trig_req),
    .step(step), .burst_end(burst_end), .blk_end(blk_end),
    .xact_end(xact_end), .busy(busy), .src_addr(src_addr), .dst_addr(dst_addr)
  );

  // {step, burst_end, blk_end, xact_end, expected src, expected dst}
  // mode 0x69: src up / reload at burst, dst down / reload at block
  localparam logic [35:0] VEC [9] = '{
    {4'b1000, 16'h1001, 16'h0001},  // R4 both sides move
    {4'b1000, 16'h1002, 16'h0000},
    {4'b1000, 16'h1003, 16'hFFFF},  // R4 down-count wraps
    {4'b0100, 16'h1000, 16'hFFFF},  // R5 burst reload on src only
    {4'b1100, 16'h1000, 16'hFFFE},  // R6 reload wins, dst keeps stepping
    {4'b1000, 16'h1001, 16'hFFFD},
    {4'b0010, 16'h1000, 16'h0002},  // R5 block end reloads both
    {4'b1000, 16'h1001, 16'h0001},
    {4'b0001, 16'h1000, 16'h0002}   // R5 transaction end reloads both
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] s, input logic trg);
    @(negedge clk);
    {step, burst_end, blk_end, xact_end} = s;
    trig_req = trg;
    @(negedge clk);
    {step, burst_end, blk_end, xact_end} = '0;
    trig_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 src", src_addr, 0);
    chk("R1 dst", dst_addr, 0);
    rd(0, rv); chk("R1 trig sel", rv, 0);
    rd(1, rv); chk("R1 mode", rv, 0);

    // R2 setup and readback
    wr(1, 8'h69);
    wr(2, 8'h00); wr(3, 8'h10);
    wr(4, 8'h02); wr(5, 8'h00);
    rd(1, rv); chk("R2 mode readback", rv, 8'h69);
    rd(3, rv); chk("R2 src high byte", rv, 8'h10);
    chk("R2 src working", src_addr, 16'h1000);
    chk("R2 dst working", dst_addr, 16'h0002);

    // R3 zero trigger select blocks start
    pulse(4'b0000, 1'b1);
    chk("R3 zero select", busy, 0);
    // R9 idle strobes ignored
    pulse(4'b1111, 1'b0);
    chk("R9 src idle", src_addr, 16'h1000);
    chk("R9 dst idle", dst_addr, 16'h0002);

    wr(0, 8'h05);
    pulse(4'b0000, 1'b1);
    chk("R3 start", busy, 1);

    for (int i = 0; i < 9; i++) begin
      pulse(VEC[i][35:32], 1'b0);
      chk($sformatf("R4/R5/R6 vec %0d src", i), src_addr, VEC[i][31:16]);
      chk($sformatf("R4/R5/R6 vec %0d dst", i), dst_addr, VEC[i][15:0]);
    end
    chk("R8 busy cleared", busy, 0);

    // R7 locks while busy
    pulse(4'b0000, 1'b1);
    chk("R7 restart", busy, 1);
    wr(1, 8'h00);
    rd(1, rv); chk("R7 mode locked", rv, 8'h69);
    wr(2, 8'h55);
    rd(2, rv); chk("R7 src byte locked", rv, 8'h00);
    wr(0, 8'h07);
    rd(0, rv); chk("R7 trig sel writable", rv, 8'h07);
    pulse(4'b1000, 1'b0);
    chk("R7 old mode still up", src_addr, 16'h1001);
    pulse(4'b0001, 1'b0);
    chk("R7 src reload start unchanged", src_addr, 16'h1000);
    chk("R8 busy cleared again", busy, 0);

    // R4 reserved hold and down count, R5 never-reload
    wr(1, 8'hF2);
    pulse(4'b0000, 1'b1);
    pulse(4'b1000, 1'b0);
    chk("R4 src down", src_addr, 16'h0FFF);
    chk("R4 dst reserved holds", dst_addr, 16'h0002);
    pulse(4'b1000, 1'b0);
    pulse(4'b0001, 1'b0);
    chk("R5 never reload", src_addr, 16'h0FFE);
    chk("R5 dst xact reload", dst_addr, 16'h0002);

    // R2 idle address write sets working value
    wr(2, 8'h34); wr(3, 8'h12);
    chk("R2 idle write", src_addr, 16'h1234);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule